// File: doc/BRIEF.md
# Serial Clock-Chip Command Engine

This block is the host-side master for a small timekeeping and parameter-memory chip that sits on three wires. One wire is an active-low select. One is a strobe driven by the master. The third is a shared data line. The host hands over a 16-bit command word and an optional write byte through a start/ready handshake. The engine selects the chip and shifts out one or two command bytes. It then either shifts out the write byte or turns the data line around and shifts in one byte from the chip. It finishes with a one-cycle done pulse.

The engine works out the length and direction of each transaction from the command word. A command word whose upper byte is zero is a short command, and only its low byte is sent. Any nonzero upper byte makes it a long command: the upper byte goes out first, then the low byte. The two lowest bits of the final command byte are always replaced by binary 01. Bit 7 of the first byte sent selects a read. For short commands the usual layout is a read flag in bit 7, a register number in bits 6:2, and 01 in bits 1:0.

The strobe period comes from a parameter that gives the number of system clocks per strobe half-period. The data line is split into an output, an output enable and an input, so the pad ring can build the bidirectional pin.

Top module: `serclk_engine`

## Requirements
- R1: After reset, sel_n_o=1, strobe_o=1, sdata_oe_o=1, ready_o=1, done_o=0 and rdata_o=0.
- R2: On an accepted start, sel_n_o goes low while strobe_o stays high for one half-period before the first bit. sel_n_o returns high right after the last data bit. The select-low window lasts exactly HALF_DIV*(1+2*N) clocks, where N is the total bit count (16 for a short command, 24 for a long one).
- R3: Each sent bit is placed on sdata_o when strobe_o falls and holds steady while strobe_o is high. The chip latches it on the rising strobe.
- R4: Bits 1:0 of the last command byte always go out as 0 then 1, whatever value cmd_i carries in bits 1:0.
- R5: When cmd_i[15:8] is nonzero, cmd_i[15:8] is sent before the modified low byte (16 command bits). Otherwise only the modified low byte is sent (8 command bits).
- R6: The transaction is a read when bit 7 of the first byte sent is 1, meaning cmd_i[15] for long commands and cmd_i[7] for short ones. Otherwise wdata_i, captured at start, is sent after the command bytes.
- R7: Bytes travel most significant bit first. During a read, sdata_oe_o is 0 for exactly the 8 received bits, starting at the first falling strobe. sdata_i is sampled at the end of each high half, rdata_o holds the byte in MSB-first order, and the line is driven again when the select rises.
- R8: start_i is ignored while ready_o is 0. A start pulse in the middle of a transaction does not change the bits sent or the byte received.
- R9: done_o is a single-cycle pulse that rises together with ready_o and sel_n_o. rdata_o is cleared at an accepted start and then holds its value until the next accepted start. After a write it reads 0.
- R10: While sel_n_o is low, every high or low level of strobe_o lasts exactly HALF_DIV clocks. HALF_DIV must be at least 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, accepted only when ready_o is 1 |
| ready_o | output | 1 | Engine idle and able to accept a command |
| cmd_i | input | 16 | Command word (upper byte nonzero selects a long command) |
| wdata_i | input | 8 | Byte to send on write transactions |
| rdata_o | output | 8 | Byte received on the last read |
| done_o | output | 1 | One-cycle end-of-transaction pulse |
| sel_n_o | output | 1 | Active-low chip select |
| strobe_o | output | 1 | Serial strobe |
| sdata_o | output | 1 | Data line output value |
| sdata_oe_o | output | 1 | Data line output enable |
| sdata_i | input | 1 | Data line input value |

## Verification
Directed commands cover the four combinations of short or long length and read or write direction. Among them are an upper byte of exactly 0x80, which is both long and read, and low bits of 00, 10 and 11, which expose whether the forced 01 suffix is applied. Random command words, write bytes and chip reply bytes then vary all of these together, so that a wrong length decision, a wrong direction bit or a bit-order error shows up as a wrong captured stream or a wrong rdata_o. Some transactions carry a stray start pulse in the middle, and after each read the bench waits idle cycles to catch any loss of rdata_o.

// File: rtl/serclk_pkg.sv
package serclk_pkg;
    localparam int BYTE_W  = 8;
    localparam int FRAME_W = 3 * BYTE_W;
    localparam int LEFT_W  = $clog2(FRAME_W + 1);

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_LOW,
        PH_HIGH
    } phase_e;

    typedef struct packed {
        phase_e              ph;
        logic [FRAME_W-1:0]  sh;
        logic [LEFT_W-1:0]   left;
        logic                rd;
        logic [BYTE_W-1:0]   rdata;
        logic                sel_n;
        logic                strobe;
        logic                sdo;
        logic                oe;
        logic                done;
    } eng_t;
endpackage

// File: rtl/serclk_halfdiv.sv
module serclk_halfdiv #(
    parameter int HALF_DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (HALF_DIV > 2) ? $clog2(HALF_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick_o = run_i && (cnt_q == LAST);
        if (!run_i || tick_o) cnt_d = '0;
        else                  cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R10
    tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
endmodule

// File: rtl/serclk_cmd_decode.sv
module serclk_cmd_decode
    import serclk_pkg::*;
(
    input  logic [15:0]        cmd_i,
    input  logic [BYTE_W-1:0]  wdata_i,
    output logic [FRAME_W-1:0] frame_o,
    output logic [LEFT_W-1:0]  nbits_o,
    output logic               rd_o
);
    logic                long_cmd;
    logic [BYTE_W-1:0]   tail_byte;

    always_comb begin
        long_cmd  = (cmd_i[15:8] != 8'h00);
        tail_byte = {cmd_i[7:2], 2'b01};
        if (long_cmd) begin
            frame_o = {cmd_i[15:8], tail_byte, wdata_i};
            nbits_o = LEFT_W'(3 * BYTE_W);
            rd_o    = cmd_i[15];
        end else begin
            frame_o = {tail_byte, wdata_i, 8'h00};
            nbits_o = LEFT_W'(2 * BYTE_W);
            rd_o    = cmd_i[7];
        end
    end
endmodule

// File: rtl/serclk_engine.sv
module serclk_engine
    import serclk_pkg::*;
#(
    parameter int HALF_DIV = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    output logic        ready_o,
    input  logic [15:0] cmd_i,
    input  logic [7:0]  wdata_i,
    output logic [7:0]  rdata_o,
    output logic        done_o,
    output logic        sel_n_o,
    output logic        strobe_o,
    output logic        sdata_o,
    output logic        sdata_oe_o,
    input  logic        sdata_i
);
    localparam logic [LEFT_W-1:0] RX_BITS = LEFT_W'(BYTE_W);

    eng_t               d, q;
    logic               tick;
    logic [FRAME_W-1:0] frame;
    logic [LEFT_W-1:0]  nbits;
    logic               rd_dec;
    logic               cur_rx, nxt_rx;

    serclk_cmd_decode u_dec (
        .cmd_i   (cmd_i),
        .wdata_i (wdata_i),
        .frame_o (frame),
        .nbits_o (nbits),
        .rd_o    (rd_dec)
    );

    serclk_halfdiv #(.HALF_DIV(HALF_DIV)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (q.ph != PH_IDLE),
        .tick_o (tick)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        cur_rx = q.rd && (q.left <= RX_BITS);
        nxt_rx = q.rd && ((q.left - 1'b1) <= RX_BITS);
        case (q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    d.ph     = PH_SETUP;
                    d.sh     = frame;
                    d.left   = nbits;
                    d.rd     = rd_dec;
                    d.rdata  = '0;
                    d.sel_n  = 1'b0;
                    d.strobe = 1'b1;
                    d.oe     = 1'b1;
                end
            end
            PH_SETUP: begin
                if (tick) begin
                    d.ph     = PH_LOW;
                    d.strobe = 1'b0;
                    d.oe     = !cur_rx;
                    d.sdo    = cur_rx ? 1'b0 : q.sh[FRAME_W-1];
                end
            end
            PH_LOW: begin
                if (tick) begin
                    d.ph     = PH_HIGH;
                    d.strobe = 1'b1;
                end
            end
            PH_HIGH: begin
                if (tick) begin
                    if (cur_rx) d.rdata = {q.rdata[BYTE_W-2:0], sdata_i};
                    d.sh   = q.sh << 1;
                    d.left = q.left - 1'b1;
                    if (q.left == LEFT_W'(1)) begin
                        d.ph    = PH_IDLE;
                        d.sel_n = 1'b1;
                        d.oe    = 1'b1;
                        d.sdo   = 1'b0;
                        d.done  = 1'b1;
                    end else begin
                        d.ph     = PH_LOW;
                        d.strobe = 1'b0;
                        d.oe     = !nxt_rx;
                        d.sdo    = nxt_rx ? 1'b0 : q.sh[FRAME_W-2];
                    end
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q        <= '0;
            q.ph     <= PH_IDLE;
            q.sel_n  <= 1'b1;
            q.strobe <= 1'b1;
            q.oe     <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign ready_o    = (q.ph == PH_IDLE);
    assign rdata_o    = q.rdata;
    assign done_o     = q.done;
    assign sel_n_o    = q.sel_n;
    assign strobe_o   = q.strobe;
    assign sdata_o    = q.sdo;
    assign sdata_oe_o = q.oe;

    // R2
    idle_strobe_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sel_n_o |-> strobe_o);
    // R3
    data_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_n_o && strobe_o && $past(strobe_o) && $past(!sel_n_o)) |-> $stable(sdata_o));
    // R7
    release_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sdata_oe_o |-> (!sel_n_o && q.rd));
    // R8
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !ready_o && !done_o) |=> $stable(q.rd));
    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    // R9
    done_with_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (ready_o && sel_n_o && sdata_oe_o));
    // R10
    strobe_min_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_o != $past(strobe_o)) |-> ($past(strobe_o, 2) == $past(strobe_o)));
endmodule

// File: tb/serclk_engine_bench.sv
module serclk_engine_bench;
    localparam int H = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [15:0] cmd = '0;
    logic [7:0]  wdata = '0;
    logic        ready, done, sel_n, strobe, sdo, oe;
    logic [7:0]  rdata;
    logic        sdi;
    logic [7:0]  rbyte = '0;

    int nvec = 0;
    int nerr = 0;
    bit finished = 1'b0;

    // chip-side monitor state
    logic [31:0] cap;
    int ntx, nfall, win, run, badrun, r3bad, oe_lo;
    logic prev_sel_n = 1'b1, prev_strobe = 1'b1, prev_sdo = 1'b0;

    always #2 clk = ~clk;

    serclk_engine #(.HALF_DIV(H)) u_serclk_engine (
        .clk(clk), .rst_n(rst_n), .start_i(start), .ready_o(ready),
        .cmd_i(cmd), .wdata_i(wdata), .rdata_o(rdata), .done_o(done),
        .sel_n_o(sel_n), .strobe_o(strobe), .sdata_o(sdo),
        .sdata_oe_o(oe), .sdata_i(sdi)
    );

    assign sdi = (!oe && nfall >= 1 && nfall <= 8) ? rbyte[8 - nfall] : 1'b0;

    always @(negedge clk) begin
        if (!sel_n) begin
            if (prev_sel_n) begin
                cap = '0; ntx = 0; nfall = 0; badrun = 0; r3bad = 0; oe_lo = 0;
                win = 1; run = 1;
            end else begin
                win++;
                if (strobe == prev_strobe) run++;
                else begin
                    if (run != H) badrun++;
                    run = 1;
                end
                if (!strobe && prev_strobe && !oe) nfall++;
                if (strobe && !prev_strobe && oe) begin
                    cap = {cap[30:0], sdo};
                    ntx++;
                end
                if (strobe && prev_strobe && sdo != prev_sdo) r3bad++;
            end
            if (!oe) oe_lo++;
        end else if (!prev_sel_n) begin
            if (run != H) badrun++;
        end
        prev_sel_n  = sel_n;
        prev_strobe = strobe;
        prev_sdo    = sdo;
    end

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic bit is_long(input logic [15:0] c);
        return c[15:8] != 8'h00;
    endfunction

    function automatic bit is_read(input logic [15:0] c);
        return is_long(c) ? c[15] : c[7];
    endfunction

    function automatic int exp_ntx(input logic [15:0] c);
        return (is_long(c) ? 16 : 8) + (is_read(c) ? 0 : 8);
    endfunction

    function automatic logic [31:0] exp_stream(input logic [15:0] c, input logic [7:0] w);
        logic [7:0] tail;
        tail = {c[7:2], 2'b01};
        if (is_long(c)) return is_read(c) ? {16'h0, c[15:8], tail} : {8'h0, c[15:8], tail, w};
        return is_read(c) ? {24'h0, tail} : {16'h0, tail, w};
    endfunction

    task automatic run_cmd(input logic [15:0] c, input logic [7:0] w, input logic [7:0] rb, input bit poke);
        int cyc;
        logic [31:0] mask;
        int total;
        @(negedge clk);
        while (!ready) @(negedge clk);
        rbyte = rb; cmd = c; wdata = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0; cmd = 16'($urandom); wdata = 8'($urandom);
        cyc = 0;
        while (!done && cyc < 5000) begin
            @(negedge clk);
            cyc++;
            start = (poke && cyc == 6);
        end
        start = 1'b0;
        check(cyc < 5000, "R9 done timeout", 32'(cyc), 32'd5000);
        check(ready && sel_n, "R9 ready/select with done", {30'h0, ready, sel_n}, 32'h3);
        @(negedge clk);
        check(!done, "R9 done single cycle", {31'h0, done}, 32'h0);
        @(negedge clk);
        total = (is_long(c) ? 16 : 8) + 8;
        mask  = (exp_ntx(c) == 32) ? 32'hFFFF_FFFF : ((32'h1 << exp_ntx(c)) - 1);
        check(ntx == exp_ntx(c), "R5 R6 sent bit count", 32'(ntx), 32'(exp_ntx(c)));
        check((cap & mask) == exp_stream(c, w), poke ? "R8 R4 R5 R6 stream under busy start" : "R4 R5 R6 sent stream",
              cap & mask, exp_stream(c, w));
        check(win == H * (1 + 2 * total), "R2 select window", 32'(win), 32'(H * (1 + 2 * total)));
        check(badrun == 0, "R10 strobe half length", 32'(badrun), 32'd0);
        check(r3bad == 0, "R3 data steady while strobe high", 32'(r3bad), 32'd0);
        if (is_read(c)) begin
            check(rdata == rb, "R7 received byte", {24'h0, rdata}, {24'h0, rb});
            check(oe_lo == 16 * H, "R7 release window", 32'(oe_lo), 32'(16 * H));
            check(nfall == 8, "R7 received bit count", 32'(nfall), 32'd8);
            repeat (10) @(negedge clk);
            check(rdata == rb, "R9 rdata held", {24'h0, rdata}, {24'h0, rb});
        end else begin
            check(rdata == 8'h00, "R9 rdata cleared on write", {24'h0, rdata}, 32'h0);
            check(oe_lo == 0, "R7 no release on write", 32'(oe_lo), 32'd0);
        end
        check(oe && sel_n && strobe, "R2 R7 idle lines", {29'h0, oe, sel_n, strobe}, 32'h7);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1
        check(sel_n && strobe && oe && ready && !done && rdata == 8'h00, "R1 reset state",
              {26'h0, sel_n, strobe, oe, ready, done, |rdata}, 32'h3C);
        rst_n = 1'b1;
        void'($urandom(32'd2024));
        // directed corners
        run_cmd(16'h0034, 8'hA5, 8'h00, 1'b0);  // R5 short write, low bits 00
        run_cmd(16'h00B6, 8'h00, 8'h5C, 1'b0);  // R6 short read, low bits 10
        run_cmd(16'h3813, 8'h3C, 8'h00, 1'b0);  // R5 long write, low bits 11
        run_cmd(16'h80FE, 8'h11, 8'hC3, 1'b0);  // R6 long read with upper 0x80
        run_cmd(16'h0000, 8'hFF, 8'h00, 1'b0);  // R4 all-zero command
        run_cmd(16'h0084, 8'h00, 8'h81, 1'b1);  // R8 stray start during read
        run_cmd(16'h7F01, 8'h96, 8'h00, 1'b1);  // R8 stray start during long write
        for (int i = 0; i < 40; i++) begin
            logic [15:0] c;
            c = 16'($urandom);
            if (($urandom % 3) == 0) c[15:8] = 8'h00;
            run_cmd(c, 8'($urandom), 8'($urandom), ($urandom % 4) == 0);
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            nvec++;
            nerr++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
            $finish;
        end
    end
endmodule